// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block gathers the interrupt sources of a serial port into one level interrupt line. Each cycle it derives a live status word from the receive and transmit FIFO fill counts, compared against two programmable trigger levels, and folds those conditions into a sticky status register. Event pulses from the serial engine set their own sticky bits. These are receive overflow, framing error, parity error, modem status change and transmit overflow.

The interrupt line is driven high when any sticky bit is also set in the mask. Software sets mask bits through one write-one-to-set register and clears them through a separate write-one-to-clear register. The mask itself is read-only. Sticky bits are cleared by writing ones to the sticky register.

A receive-idle timer is built in. Each accepted character reloads it with four character times, counted in baud ticks. The character length in baud ticks is an input. When the timer runs out and the timeout configuration register is non-zero, the timeout sticky bit is raised.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The live status word (read at address 7) has receive count >= receive trigger at bit 0, receive empty (count 0) at bit 1, receive full (count = FIFO_DEPTH) at bit 2, transmit empty at bit 3 and transmit full at bit 4.
- R2: Transmit count >= transmit trigger appears at bit 13 of the live status word and sets bit 10 of the sticky register.
- R3: Every cycle, each set live bit 0 to 4 is ORed into the same sticky bit, and a sticky bit stays set after its condition goes away until it is cleared by software.
- R4: A write to address 0 ORs wr_data[12:0] into the mask, and a write to address 1 clears from the mask each bit written as 1.
- R5: A write to address 2 (the mask readback) leaves the mask unchanged.
- R6: A write to address 3 clears each sticky bit written as 1 and leaves the other sticky bits unchanged.
- R7: irq is a register that equals the OR of (mask AND sticky) as held in the registers during that same cycle.
- R8: One-cycle pulses on ev_rx_ovr, ev_frame, ev_parity, ev_modem and ev_tx_ovr set sticky bits 5, 6, 7, 9 and 12 respectively.
- R9: A pulse on rx_char loads the timer with 4*char_time baud ticks and restarts it if it is already running. The timer expires on the baud tick that exhausts this count, or on the first tick when the count is 0. On expiry, sticky bit 8 is set if and only if the timeout configuration (address 6) is non-zero. An rx_char pulse in the same cycle as a tick cancels the expiry.
- R10: If a condition sets a sticky bit in the same cycle that a write clears it, the bit ends up set.
- R11: After reset, the mask, the timeout configuration, rd_data and irq are zero, and both trigger levels (address 4 for receive, address 5 for transmit) read 32.
- R12: rd_data is registered. It shows, one cycle later, the register selected by rd_addr (0 and 1 read the mask, 2 the mask, 3 sticky, 4 and 5 the triggers, 6 the timeout configuration, 7 the live word), zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | CNT_W | Receive FIFO fill count |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| rx_char | input | 1 | Pulse: a receive character was accepted |
| baud_tick | input | 1 | Pulse: one baud period elapsed |
| char_time | input | CT_W | Character length in baud ticks |
| ev_rx_ovr | input | 1 | Pulse: receive overflow |
| ev_frame | input | 1 | Pulse: framing error |
| ev_parity | input | 1 | Pulse: parity error |
| ev_modem | input | 1 | Pulse: modem status change |
| ev_tx_ovr | input | 1 | Pulse: transmit overflow |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with FIFO_DEPTH 64 and an 8-bit char_time. The default trigger level of 32 then sits mid-range, and the full, empty and at-or-above-trigger conditions can all be reached with small count values. During the timer phases the bench keeps char_time at 3 or below, so each timeout lasts only a dozen baud ticks. Restarting the timer and expiring it with the timeout configuration both zero and non-zero therefore take just tens of cycles. A long random phase mixes trigger rewrites, clear and set writes, event pulses and character pulses. Many of these land in the same cycle as a condition that sets a bit being cleared.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IRQ_W  = 13;
  localparam int LIVE_W = 14;

  localparam int B_RX_LVL  = 0;
  localparam int B_RX_EMP  = 1;
  localparam int B_RX_FUL  = 2;
  localparam int B_TX_EMP  = 3;
  localparam int B_TX_FUL  = 4;
  localparam int B_RX_OVR  = 5;
  localparam int B_FRAME   = 6;
  localparam int B_PARITY  = 7;
  localparam int B_TMO     = 8;
  localparam int B_MODEM   = 9;
  localparam int B_TX_LVL  = 10;
  localparam int B_TX_OVR  = 12;
  localparam int L_TX_LVL  = 13;

  typedef enum logic [2:0] {
    A_MSET   = 3'd0,
    A_MCLR   = 3'd1,
    A_MASK   = 3'd2,
    A_STICKY = 3'd3,
    A_RXTRIG = 3'd4,
    A_TXTRIG = 3'd5,
    A_TOCFG  = 3'd6,
    A_LIVE   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/uart_irq_live.sv
module uart_irq_live
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_trig,
  input  logic [CNT_W-1:0]  tx_trig,
  output logic [LIVE_W-1:0] live
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);

  always_comb begin
    live           = '0;
    live[B_RX_LVL] = (rx_count >= rx_trig);
    live[B_RX_EMP] = (rx_count == '0);
    live[B_RX_FUL] = (rx_count == FULL);
    live[B_TX_EMP] = (tx_count == '0);
    live[B_TX_FUL] = (tx_count == FULL);
    live[L_TX_LVL] = (tx_count >= tx_trig);
  end
endmodule

// File: rtl/uart_irq_rxto.sv
module uart_irq_rxto #(
  parameter int CT_W  = 8,
  parameter int TMR_W = CT_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_char,
  input  logic            baud_tick,
  input  logic [CT_W-1:0] char_time,
  output logic            expire
);
  logic [TMR_W-1:0] cnt_q;
  logic             armed_q;

  // Expiry on the tick that exhausts the count; a new character wins.
  assign expire = armed_q && baud_tick && !rx_char && (cnt_q <= TMR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (rx_char) begin
      cnt_q   <= {char_time, 2'b00};
      armed_q <= 1'b1;
    end else if (armed_q && baud_tick) begin
      if (cnt_q <= TMR_W'(1)) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - TMR_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int DATA_W   = 32,
  parameter int TO_W     = 8,
  parameter int TRIG_RST = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  input  logic [IRQ_W-1:0]  set_vec,
  input  logic [LIVE_W-1:0] live,
  output logic [IRQ_W-1:0]  mask_q,
  output logic [IRQ_W-1:0]  sticky_q,
  output logic [CNT_W-1:0]  rx_trig_q,
  output logic [CNT_W-1:0]  tx_trig_q,
  output logic [TO_W-1:0]   tocfg_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [IRQ_W-1:0] wbits, clr_vec, mask_n, sticky_n;
  reg_addr_e        waddr, raddr;

  assign waddr = reg_addr_e'(wr_addr);
  assign raddr = reg_addr_e'(rd_addr);
  assign wbits = wr_data[IRQ_W-1:0];

  always_comb begin
    clr_vec  = (wr_en && waddr == A_STICKY) ? wbits : '0;
    sticky_n = (sticky_q & ~clr_vec) | set_vec;
    mask_n   = mask_q;
    if (wr_en && waddr == A_MSET) mask_n = mask_q | wbits;
    if (wr_en && waddr == A_MCLR) mask_n = mask_q & ~wbits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      sticky_q  <= '0;
      rx_trig_q <= CNT_W'(TRIG_RST);
      tx_trig_q <= CNT_W'(TRIG_RST);
      tocfg_q   <= '0;
      irq       <= 1'b0;
    end else begin
      mask_q   <= mask_n;
      sticky_q <= sticky_n;
      irq      <= |(mask_n & sticky_n);
      if (wr_en && waddr == A_RXTRIG) rx_trig_q <= wr_data[CNT_W-1:0];
      if (wr_en && waddr == A_TXTRIG) tx_trig_q <= wr_data[CNT_W-1:0];
      if (wr_en && waddr == A_TOCFG)  tocfg_q   <= wr_data[TO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (raddr)
        A_MSET, A_MCLR, A_MASK: rd_data <= DATA_W'(mask_q);
        A_STICKY: rd_data <= DATA_W'(sticky_q);
        A_RXTRIG: rd_data <= DATA_W'(rx_trig_q);
        A_TXTRIG: rd_data <= DATA_W'(tx_trig_q);
        A_TOCFG:  rd_data <= DATA_W'(tocfg_q);
        A_LIVE:   rd_data <= DATA_W'(live);
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int CT_W       = 8,
  parameter int DATA_W     = 32,
  parameter int TO_W       = 8,
  parameter int TRIG_RST   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              rx_char,
  input  logic              baud_tick,
  input  logic [CT_W-1:0]   char_time,
  input  logic              ev_rx_ovr,
  input  logic              ev_frame,
  input  logic              ev_parity,
  input  logic              ev_modem,
  input  logic              ev_tx_ovr,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [LIVE_W-1:0] live;
  logic [IRQ_W-1:0]  set_vec, mask_q, sticky_q;
  logic [CNT_W-1:0]  rx_trig_q, tx_trig_q;
  logic [TO_W-1:0]   tocfg_q;
  logic              tmo_expire;

  uart_irq_live #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) live_i (
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_trig(rx_trig_q), .tx_trig(tx_trig_q), .live(live)
  );

  uart_irq_rxto #(.CT_W(CT_W)) rxto_i (
    .clk(clk), .rst(rst), .rx_char(rx_char), .baud_tick(baud_tick),
    .char_time(char_time), .expire(tmo_expire)
  );

  // Live bits 0..4 keep their position; the rest are remapped or events.
  always_comb begin
    set_vec                        = '0;
    set_vec[B_TX_FUL:B_RX_LVL]     = live[B_TX_FUL:B_RX_LVL];
    set_vec[B_TX_LVL]              = live[L_TX_LVL];
    set_vec[B_RX_OVR]              = ev_rx_ovr;
    set_vec[B_FRAME]               = ev_frame;
    set_vec[B_PARITY]              = ev_parity;
    set_vec[B_MODEM]               = ev_modem;
    set_vec[B_TX_OVR]              = ev_tx_ovr;
    set_vec[B_TMO]                 = tmo_expire && (tocfg_q != '0);
  end

  uart_irq_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .TO_W(TO_W), .TRIG_RST(TRIG_RST)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .set_vec(set_vec), .live(live),
    .mask_q(mask_q), .sticky_q(sticky_q), .rx_trig_q(rx_trig_q),
    .tx_trig_q(tx_trig_q), .tocfg_q(tocfg_q), .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
  import uart_irq_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int DATA_W = 32,
  parameter int TO_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  rx_count,
  input logic              irq,
  input logic [IRQ_W-1:0]  mask_q,
  input logic [IRQ_W-1:0]  sticky_q,
  input logic [TO_W-1:0]   tocfg_q
);
  logic [IRQ_W-1:0] clr_req;
  assign clr_req = (wr_en && wr_addr == 3'd3) ? wr_data[IRQ_W-1:0] : '0;

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    irq == |(mask_q & sticky_q));

  assert_sticky_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (($past(sticky_q) & ~$past(clr_req)) & ~sticky_q) == '0);

  assert_mask_readonly_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd2) |=> $stable(mask_q));

  assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0) |=>
      ((mask_q & $past(wr_data[IRQ_W-1:0])) == $past(wr_data[IRQ_W-1:0])));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0) |=> sticky_q[B_RX_EMP]);

  assert_timeout_gated_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sticky_q[B_TMO]) |-> ($past(tocfg_q) != '0));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .TO_W(TO_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rx_count(rx_count), .irq(irq), .mask_q(mask_q), .sticky_q(sticky_q),
  .tocfg_q(tocfg_q)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb_top;
  localparam int DEPTH = 64;
  localparam int CW    = 7;
  localparam int CTW   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] rx_count = '0, tx_count = '0;
  logic rx_char = 0, baud_tick = 0;
  logic [CTW-1:0] char_time = '0;
  logic ev_rx_ovr = 0, ev_frame = 0, ev_parity = 0, ev_modem = 0, ev_tx_ovr = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq;

  always #4 clk = ~clk;

  uart_irq_ctrl #(.FIFO_DEPTH(DEPTH), .CT_W(CTW)) dut_i (
    .clk(clk), .rst(rst), .rx_count(rx_count), .tx_count(tx_count),
    .rx_char(rx_char), .baud_tick(baud_tick), .char_time(char_time),
    .ev_rx_ovr(ev_rx_ovr), .ev_frame(ev_frame), .ev_parity(ev_parity),
    .ev_modem(ev_modem), .ev_tx_ovr(ev_tx_ovr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;
  string req = "R11";

  // Behavioural reference model
  int m_mask, m_sticky, m_rxl, m_txl, m_toc, m_cnt;
  bit m_armed, m_irq;
  logic [31:0] m_rd;

  function automatic int live_word(int rxl, int txl);
    int w = 0;
    if (int'(rx_count) >= rxl) w |= 1;
    if (rx_count == 0) w |= 2;
    if (int'(rx_count) == DEPTH) w |= 4;
    if (tx_count == 0) w |= 8;
    if (int'(tx_count) == DEPTH) w |= 16;
    if (int'(tx_count) >= txl) w |= 32'h2000;
    return w;
  endfunction

  always @(posedge clk) begin
    int lw, setv, clr, nm, ns;
    bit ex;
    if (rst) begin
      m_mask = 0; m_sticky = 0; m_rxl = 32; m_txl = 32; m_toc = 0;
      m_cnt = 0; m_armed = 0; m_irq = 0; m_rd = 0;
    end else begin
      lw = live_word(m_rxl, m_txl);
      case (rd_addr)
        3'd0, 3'd1, 3'd2: m_rd = m_mask;
        3'd3: m_rd = m_sticky;
        3'd4: m_rd = m_rxl;
        3'd5: m_rd = m_txl;
        3'd6: m_rd = m_toc;
        default: m_rd = lw;
      endcase
      ex = m_armed && baud_tick && !rx_char && (m_cnt <= 1);
      setv = (lw & 32'h1F) | (((lw >> 13) & 1) << 10)
           | (int'(ev_rx_ovr) << 5) | (int'(ev_frame) << 6)
           | (int'(ev_parity) << 7) | (int'(ev_modem) << 9)
           | (int'(ev_tx_ovr) << 12) | (int'(ex && m_toc != 0) << 8);
      clr = (wr_en && wr_addr == 3) ? (wr_data & 32'h1FFF) : 0;
      ns = (m_sticky & ~clr) | setv;
      nm = m_mask;
      if (wr_en && wr_addr == 0) nm = nm | (wr_data & 32'h1FFF);
      if (wr_en && wr_addr == 1) nm = nm & ~wr_data & 32'h1FFF;
      if (wr_en && wr_addr == 4) m_rxl = wr_data & 32'h7F;
      if (wr_en && wr_addr == 5) m_txl = wr_data & 32'h7F;
      if (wr_en && wr_addr == 6) m_toc = wr_data & 32'hFF;
      if (rx_char) begin
        m_cnt = 4 * int'(char_time); m_armed = 1;
      end else if (m_armed && baud_tick) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_armed = 0; end
        else m_cnt = m_cnt - 1;
      end
      m_sticky = ns; m_mask = nm;
      m_irq = ((nm & ns) != 0);
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (irq !== m_irq || rd_data !== m_rd) begin
        fails++;
        $display("FAIL %s irq/rd_data actual %0b/%08h expected %0b/%08h",
                 req, irq, rd_data, m_irq, m_rd);
      end
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %08h expected %08h", r, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    step();
    v = rd_data;
  endtask

  task automatic tick();
    baud_tick = 1; step(); baud_tick = 0; step();
  endtask

  task automatic pulse_char();
    rx_char = 1; step(); rx_char = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    step(3);
    chk("R11 irq in reset", {31'b0, irq}, 0);
    chk("R11 rd_data in reset", rd_data, 0);
    rx_count = 10; tx_count = 5;
    rst = 0;
    req = "R11";
    rd(3'd4, v); chk("R11 rx trigger", v, 32);
    rd(3'd5, v); chk("R11 tx trigger", v, 32);
    rd(3'd6, v); chk("R11 timeout cfg", v, 0);
    rd(3'd2, v); chk("R11 mask", v, 0);
    rd(3'd3, v); chk("R11 sticky", v, 0);

    // R1, R2: live word under several count patterns
    req = "R1";
    rx_count = 40; tx_count = 64;
    rd(3'd7, v); chk("R1 R2 live word", v, 32'h2011);
    rx_count = 64; tx_count = 0;
    rd(3'd7, v); chk("R1 live full/empty", v, 32'h0000000D);
    rx_count = 0; tx_count = 33;
    rd(3'd7, v); chk("R1 R2 live empty/trig", v, 32'h2002);
    req = "R2";
    rx_count = 10; tx_count = 5;
    wr(3'd3, 32'h1FFF);
    rd(3'd3, v); chk("R2 sticky after clear", v, 0);
    tx_count = 40; step();
    tx_count = 5;
    rd(3'd3, v); chk("R2 tx trigger sets sticky bit 10", v, 32'h400);
    wr(3'd4, 8); wr(3'd5, 2);
    rd(3'd7, v); chk("R1 R2 reprogrammed triggers", v, 32'h2001);
    wr(3'd4, 32); wr(3'd5, 32);
    wr(3'd3, 32'h1FFF);

    // R10, R3, R6: set beats clear, stickiness, write-one-to-clear
    req = "R10";
    rx_count = 0;
    step();
    wr(3'd3, 32'h1FFF);
    rd(3'd3, v); chk("R10 set wins over clear", v, 32'h2);
    req = "R3";
    rx_count = 10;
    step(2);
    rd(3'd3, v); chk("R3 sticky survives condition", v, 32'h2);
    req = "R6";
    ev_frame = 1; step(); ev_frame = 0;
    wr(3'd3, 32'h2);
    rd(3'd3, v); chk("R6 partial clear", v, 32'h40);
    wr(3'd3, 32'h40);
    rd(3'd3, v); chk("R6 cleared", v, 0);

    // R4, R5, R7: mask set/clear, read-only mask, interrupt level
    req = "R4";
    wr(3'd0, 32'h3);
    rd(3'd2, v); chk("R4 mask set", v, 3);
    wr(3'd1, 32'h1);
    rd(3'd2, v); chk("R4 mask clear", v, 2);
    req = "R5";
    wr(3'd2, 32'hFFF);
    rd(3'd2, v); chk("R5 mask write ignored", v, 2);
    req = "R7";
    chk("R7 irq low", {31'b0, irq}, 0);
    rx_count = 0; step(); rx_count = 10;
    step();
    chk("R7 irq high", {31'b0, irq}, 1);
    wr(3'd1, 32'h2);
    chk("R7 irq low after mask clear", {31'b0, irq}, 0);
    wr(3'd0, 32'h2);
    chk("R7 irq high after mask set", {31'b0, irq}, 1);
    wr(3'd3, 32'h2);
    chk("R7 irq low after sticky clear", {31'b0, irq}, 0);

    // R8: event pulses
    req = "R8";
    wr(3'd0, 32'h1FFF);
    ev_rx_ovr = 1; step(); ev_rx_ovr = 0;
    ev_parity = 1; step(); ev_parity = 0;
    ev_modem = 1; step(); ev_modem = 0;
    ev_tx_ovr = 1; step(); ev_tx_ovr = 0;
    rd(3'd3, v); chk("R8 event bits", v, 32'h12A0);
    wr(3'd3, 32'h1FFF);

    // R9: receive timeout timer
    req = "R9";
    wr(3'd6, 1);
    char_time = 3;
    pulse_char();
    repeat (11) tick();
    rd(3'd3, v); chk("R9 no timeout before 12 ticks", v, 0);
    tick();
    rd(3'd3, v); chk("R9 timeout at 12 ticks", v, 32'h100);
    wr(3'd3, 32'h100);
    pulse_char();
    repeat (6) tick();
    pulse_char();
    repeat (11) tick();
    rd(3'd3, v); chk("R9 restart delays timeout", v, 0);
    tick();
    rd(3'd3, v); chk("R9 timeout after restart", v, 32'h100);
    wr(3'd3, 32'h100);
    wr(3'd6, 0);
    pulse_char();
    repeat (13) tick();
    rd(3'd3, v); chk("R9 timeout gated by cfg", v, 0);
    char_time = 0; wr(3'd6, 5);
    pulse_char(); tick();
    rd(3'd3, v); chk("R9 zero char time", v, 32'h100);

    // R12 and mixed: random traffic checked against the model every cycle
    req = "R12";
    for (int i = 0; i < 6000; i++) begin
      rx_count  = CW'($urandom_range(0, 3) == 0 ? $urandom_range(0, 64) :
                      (($urandom_range(0, 1) == 0) ? 0 : 64));
      tx_count  = CW'($urandom_range(0, 64));
      rx_char   = ($urandom_range(0, 15) == 0);
      baud_tick = ($urandom_range(0, 2) == 0);
      char_time = CTW'($urandom_range(0, 3));
      ev_rx_ovr = ($urandom_range(0, 31) == 0);
      ev_frame  = ($urandom_range(0, 31) == 0);
      ev_parity = ($urandom_range(0, 31) == 0);
      ev_modem  = ($urandom_range(0, 31) == 0);
      ev_tx_ovr = ($urandom_range(0, 31) == 0);
      wr_en     = ($urandom_range(0, 2) == 0);
      wr_addr   = 3'($urandom_range(0, 7));
      wr_data   = (wr_addr == 3'd4 || wr_addr == 3'd5) ?
                  32'($urandom_range(0, 70)) : $urandom;
      rd_addr   = 3'($urandom_range(0, 7));
      step();
    end
    wr_en = 0; rx_char = 0; baud_tick = 0;
    step(2);
    finish_run();
  end
endmodule